// File: doc/BRIEF.md
# Two-Bank Edge-Interrupt GPIO Controller

This block is a register-mapped general-purpose I/O controller whose 32-bit register word covers two banks of 16 pins. Software sets each pin's direction and changes output levels only through write-one-to-set and write-one-to-clear registers, so no read-modify-write sequence is needed. Every pin level passes through a two-flop synchronizer before software can read it. That holds even when the pin drives an output, so a loopback read of a fresh output write shows the old level for a short time.

Each pin has its own rising-edge and falling-edge detector. Each detector has an enable, and each enable is changed through its own set and clear registers. A detected enabled edge latches a sticky status bit, and software clears that bit by writing a 1 to it. Bits 15:0 of every register belong to the lower bank and bits 31:16 to the upper bank. Each bank has its own interrupt line, which is gated by that bank's enable bit.

Bus access uses a word index `bus_addr`, a single-cycle write strobe, write data, and read data that follows the address combinationally. The word indices are: 0 direction, 1 output set, 2 output clear, 3 input level, 4 rise-enable set, 5 rise-enable clear, 6 fall-enable set, 7 fall-enable clear, 8 status, 9 bank enable.

Top module: `gpbank_ctrl`

## Requirements
- R1: After reset, every direction bit is 1 (all `pin_oe` low), outputs, edge enables, status and bank enables are 0, and both `bank_irq` lines are low.
- R2: Direction register (index 0) bit 1 makes the pin an input (`pin_oe` bit 0). Bit 0 makes it an output (`pin_oe` bit 1). `pin_out` carries the output register in both cases. The value is visible on the pins from the edge after the write.
- R3: Writing a mask to index 1 sets the masked output bits and writing to index 2 clears them. Zero bits are unchanged. Reads of either index return the output register.
- R4: The input register (index 3) returns the pin level after two clock edges of synchronization, including for pins configured as outputs.
- R5: Rise enables are set by writing ones to index 4 and cleared by writing ones to index 5. Reads of either index return the rise-enable state. A cleared enable stops rising edges from setting status.
- R6: A rising edge on a rise-enabled pin sets its status bit (index 8) on the third clock edge after the pin changes. A falling edge on that pin, without a fall enable, sets nothing.
- R7: Fall enables use index 6 (set) and index 7 (clear) in the same way. A falling edge on a fall-enabled pin sets its status bit, and a rising edge on a pin with only a fall enable sets nothing.
- R8: A pin with neither edge enabled never sets its status bit.
- R9: Writing ones to index 8 clears those status bits. Zero bits, and every cycle without a status write, leave status bits unchanged.
- R10: An enabled edge detected in the same cycle as a write-one clear of that status bit leaves the bit set.
- R11: `bank_irq[b]` is high exactly while some status bit of bank b (bits 16b+15:16b) is set and bit b of the bank-enable register (index 9) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register word index |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output register value |
| pin_oe | output | 32 | Per-pin output enable |
| bank_irq | output | 2 | Per-bank interrupt lines |

## Verification
A register write takes effect at the clock edge that samples the strobe, so `pin_out`, `pin_oe` and register reads are checked on the falling edge right after that edge. A pin change is visible in the input register two edges later, and status and `bank_irq` respond one edge after that. The bench changes pins on a falling edge and samples on the falling edges before and after each due edge, so an extra or a missing register stage shows up as a failure. The same-cycle clear case is set up by timing the clear write to commit at exactly the edge on which the status bit would be set.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_DIR  = 4'd0,
        RA_OSET = 4'd1,
        RA_OCLR = 4'd2,
        RA_IN   = 4'd3,
        RA_RSET = 4'd4,
        RA_RCLR = 4'd5,
        RA_FSET = 4'd6,
        RA_FCLR = 4'd7,
        RA_STS  = 4'd8,
        RA_BEN  = 4'd9
    } reg_addr_e;

    typedef struct packed {
        logic dir;
        logic oset;
        logic oclr;
        logic rset;
        logic rclr;
        logic fset;
        logic fclr;
        logic sts_clr;
        logic ben;
    } wr_dec_t;

    function automatic wr_dec_t decode_write(input logic we, input logic [ADDR_W-1:0] a);
        wr_dec_t d;
        d = '0;
        if (we) begin
            case (a)
                RA_DIR:  d.dir     = 1'b1;
                RA_OSET: d.oset    = 1'b1;
                RA_OCLR: d.oclr    = 1'b1;
                RA_RSET: d.rset    = 1'b1;
                RA_RCLR: d.rclr    = 1'b1;
                RA_FSET: d.fset    = 1'b1;
                RA_FCLR: d.fclr    = 1'b1;
                RA_STS:  d.sts_clr = 1'b1;
                RA_BEN:  d.ben     = 1'b1;
                default: d         = '0;
            endcase
        end
        return d;
    endfunction
endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q_now,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta   <= '0;
            q_now  <= '0;
            q_prev <= '0;
        end else begin
            meta   <= d;
            q_now  <= meta;
            q_prev <= q_now;
        end
    end
endmodule

// File: rtl/gpb_edge_stat.sv
module gpb_edge_stat #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic         clr_we,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] sts
);
    logic [W-1:0] hit;
    logic [W-1:0] wipe;

    always_comb begin
        hit  = (cur & ~prev & rise_en) | (~cur & prev & fall_en);
        wipe = clr_we ? clr_mask : '0;
    end

    // a new edge takes priority over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) sts <= '0;
        else     sts <= (sts & ~wipe) | hit;
    end
endmodule

// File: rtl/gpb_regs.sv
module gpb_regs
    import gpb_pkg::*;
#(
    parameter int W  = 32,
    parameter int NB = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      lvl,
    input  logic [W-1:0]      sts,
    output logic [W-1:0]      rdata,
    output logic [W-1:0]      dir,
    output logic [W-1:0]      dout,
    output logic [W-1:0]      rise_en,
    output logic [W-1:0]      fall_en,
    output logic [NB-1:0]     ben,
    output logic              sts_clr
);
    wr_dec_t wd;

    always_comb wd = decode_write(wr, addr);
    assign sts_clr = wd.sts_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir     <= '1;
            dout    <= '0;
            rise_en <= '0;
            fall_en <= '0;
            ben     <= '0;
        end else begin
            if (wd.dir)  dir     <= wdata;
            if (wd.oset) dout    <= dout | wdata;
            if (wd.oclr) dout    <= dout & ~wdata;
            if (wd.rset) rise_en <= rise_en | wdata;
            if (wd.rclr) rise_en <= rise_en & ~wdata;
            if (wd.fset) fall_en <= fall_en | wdata;
            if (wd.fclr) fall_en <= fall_en & ~wdata;
            if (wd.ben)  ben     <= wdata[NB-1:0];
        end
    end

    always_comb begin
        case (addr)
            RA_DIR:           rdata = dir;
            RA_OSET, RA_OCLR: rdata = dout;
            RA_IN:            rdata = lvl;
            RA_RSET, RA_RCLR: rdata = rise_en;
            RA_FSET, RA_FCLR: rdata = fall_en;
            RA_STS:           rdata = sts;
            RA_BEN:           rdata = {{(W-NB){1'b0}}, ben};
            default:          rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpbank_ctrl.sv
module gpbank_ctrl
    import gpb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BANK_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_wr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic [DATA_W-1:0]        pin_in,
    output logic [DATA_W-1:0]        pin_out,
    output logic [DATA_W-1:0]        pin_oe,
    output logic [DATA_W/BANK_W-1:0] bank_irq
);
    localparam int NBANK = DATA_W / BANK_W;

    logic [DATA_W-1:0] lvl_now, lvl_prev;
    logic [DATA_W-1:0] dir_q, rise_q, fall_q, irq_sts;
    logic [NBANK-1:0]  bank_en;
    logic              sts_clr_we;

    gpb_sync #(.W(DATA_W)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q_now(lvl_now), .q_prev(lvl_prev)
    );

    gpb_regs #(.W(DATA_W), .NB(NBANK)) u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
        .lvl(lvl_now), .sts(irq_sts), .rdata(bus_rdata), .dir(dir_q),
        .dout(pin_out), .rise_en(rise_q), .fall_en(fall_q), .ben(bank_en),
        .sts_clr(sts_clr_we)
    );

    gpb_edge_stat #(.W(DATA_W)) u_edge (
        .clk(clk), .rst(rst), .cur(lvl_now), .prev(lvl_prev),
        .rise_en(rise_q), .fall_en(fall_q), .clr_we(sts_clr_we),
        .clr_mask(bus_wdata), .sts(irq_sts)
    );

    assign pin_oe = ~dir_q;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign bank_irq[b] = bank_en[b] & (|irq_sts[b*BANK_W +: BANK_W]);
    end
endmodule

// File: rtl/gpbank_chk.sv
module gpbank_chk
    import gpb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NBANK  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] pin_out,
    input logic [DATA_W-1:0] pin_oe,
    input logic [NBANK-1:0]  bank_irq,
    input logic [DATA_W-1:0] sts,
    input logic [NBANK-1:0]  ben
);
    // R2
    dir_oe_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_DIR) |=> (pin_oe == ~$past(bus_wdata)));

    // R3
    out_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_OSET) |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

    // R3
    out_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_OCLR) |=> ((pin_out & $past(bus_wdata)) == '0));

    // R9
    sts_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == RA_STS) |=> ((sts & $past(sts)) == $past(sts)));

    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ((bank_irq & ~ben) == '0));
endmodule

bind gpbank_ctrl gpbank_chk #(.DATA_W(DATA_W), .NBANK(DATA_W/BANK_W)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe),
    .bank_irq(bank_irq), .sts(irq_sts), .ben(bank_en)
);

// File: tb/gpbank_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpbank_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, pin_in, pin_out, pin_oe;
    logic [1:0]  bank_irq;
    logic [31:0] ext_in = '0;
    logic        loop = 1'b0;
    int          n_run = 0, n_bad = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;
    assign pin_in = loop ? pin_out : ext_in;

    gpbank_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .bank_irq(bank_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        check("R1 oe", pin_oe, 32'h0);
        check("R1 out", pin_out, 32'h0);
        check("R1 irq", {30'h0, bank_irq}, 32'h0);
        rd(4'd0, rv); check("R1 dir", rv, 32'hFFFF_FFFF);
        rd(4'd8, rv); check("R1 sts", rv, 32'h0);
        rd(4'd4, rv); check("R1 rise", rv, 32'h0);
    endtask

    task automatic t_dir_out;
        wr(4'd0, 32'hFFFF_0000);
        check("R2 oe", pin_oe, 32'h0000_FFFF);
        wr(4'd1, 32'h0000_00A5);
        wr(4'd1, 32'h0000_0100);
        check("R3 set", pin_out, 32'h0000_01A5);
        wr(4'd2, 32'h0000_0005);
        check("R3 clr", pin_out, 32'h0000_01A0);
        rd(4'd1, rv); check("R3 rd set", rv, 32'h0000_01A0);
        rd(4'd2, rv); check("R3 rd clr", rv, 32'h0000_01A0);
        wr(4'd1, 32'h8000_0000);
        check("R2 out on input pin", pin_out, 32'h8000_01A0);
        check("R2 oe unchanged", pin_oe, 32'h0000_FFFF);
        wr(4'd2, 32'h8000_0000);
    endtask

    task automatic t_input_sync;
        loop = 1'b1;
        tick(4);
        rd(4'd3, rv); check("R4 loopback", rv, 32'h0000_01A0);
        wr(4'd1, 32'h0000_0002);
        rd(4'd3, rv); check("R4 +0 edges", rv, 32'h0000_01A0);
        tick(1);
        rd(4'd3, rv); check("R4 +1 edge", rv, 32'h0000_01A0);
        tick(1);
        rd(4'd3, rv); check("R4 +2 edges", rv, 32'h0000_01A2);
        loop = 1'b0;
        ext_in = '0;
        tick(4);
        rd(4'd3, rv); check("R4 ext", rv, 32'h0);
    endtask

    task automatic t_rise_fall;
        wr(4'd9, 32'h3);
        wr(4'd4, 32'h0000_0001);
        wr(4'd6, 32'h0001_0000);
        rd(4'd4, rv); check("R5 rd set", rv, 32'h1);
        rd(4'd5, rv); check("R5 rd clr", rv, 32'h1);
        rd(4'd7, rv); check("R7 rd clr", rv, 32'h0001_0000);
        ext_in[0] = 1'b1;
        tick(2);
        rd(4'd8, rv); check("R6 early", rv, 32'h0);
        check("R11 early", {30'h0, bank_irq}, 32'h0);
        tick(1);
        rd(4'd8, rv); check("R6 due", rv, 32'h1);
        check("R11 bank0", {30'h0, bank_irq}, 32'h1);
        ext_in[0] = 1'b0;
        tick(4);
        rd(4'd8, rv); check("R6 fall ignored", rv, 32'h1);
        wr(4'd8, 32'h0);
        rd(4'd8, rv); check("R9 zero write", rv, 32'h1);
        wr(4'd8, 32'h1);
        rd(4'd8, rv); check("R9 clear", rv, 32'h0);
        check("R11 after clear", {30'h0, bank_irq}, 32'h0);
        ext_in[16] = 1'b1;
        tick(4);
        rd(4'd8, rv); check("R7 rise ignored", rv, 32'h0);
        ext_in[16] = 1'b0;
        tick(3);
        rd(4'd8, rv); check("R7 fall", rv, 32'h0001_0000);
        check("R11 bank1", {30'h0, bank_irq}, 32'h2);
        wr(4'd9, 32'h1);
        check("R11 gated", {30'h0, bank_irq}, 32'h0);
        rd(4'd8, rv); check("R11 sts kept", rv, 32'h0001_0000);
        wr(4'd9, 32'h3);
        wr(4'd8, 32'h0001_0000);
    endtask

    task automatic t_no_enable;
        ext_in[5] = 1'b1;
        tick(4);
        ext_in[5] = 1'b0;
        tick(4);
        rd(4'd8, rv); check("R8 none", rv, 32'h0);
        wr(4'd5, 32'h1);
        rd(4'd4, rv); check("R5 cleared", rv, 32'h0);
        ext_in[0] = 1'b1;
        tick(4);
        rd(4'd8, rv); check("R5 disabled", rv, 32'h0);
        ext_in[0] = 1'b0;
        tick(4);
    endtask

    task automatic t_clear_race;
        wr(4'd4, 32'h4);
        ext_in[2] = 1'b1;
        tick(3);
        rd(4'd8, rv); check("R10 setup", rv, 32'h4);
        ext_in[2] = 1'b0;
        tick(4);
        ext_in[2] = 1'b1;
        tick(2);
        wr(4'd8, 32'h4);
        rd(4'd8, rv); check("R10 race kept", rv, 32'h4);
        wr(4'd8, 32'h4);
        rd(4'd8, rv); check("R10 later clear", rv, 32'h0);
    endtask

    initial begin
        #(5.0 * 200000);
        n_run++;
        n_bad++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset;
        t_dir_out;
        t_input_sync;
        t_rise_fall;
        t_no_enable;
        t_clear_race;
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule